// File: doc/BRIEF.md
# Reconfigurable-Aspect Dual-Port RAM

This block holds 4,608 bits of storage behind one write port and one independent read port. A static organisation code picks one of six word shapes, from 128 words of 36 bits down to 4096 words of 1 bit. Every shape is folded onto a single array of 128 rows of 36 bits. A narrow word is a slice of one row, chosen by the low address bits, and a narrow write changes only that slice.

Reads are synchronous. The read data and a collision flag appear one clock after the read enable is sampled, and both hold while no read is issued. A write and a read may be issued in the same cycle. When both target the same word in the current organisation, the write still lands and the read returns the word's earlier content, but the collision flag marks that read as not trustworthy. Changing the organisation reinterprets the stored bits under the new mapping. It is only legal while both ports are idle.

Top module: `ar_dpram`

## Requirements
- R1: With `org_i` = 0 (128x36) a write stores all 36 bits of `wdata_i` in row `waddr_i[6:0]`, and a later read of that address returns them.
- R2: `org_i` codes 1..5 select 256x18, 512x9, 1024x4, 2048x2 and 4096x1. Codes 6 and 7 behave as code 0. Read data sits in the low W bits of `rdata_o` and all bits above W read 0.
- R3: In organisation code m (m>0) a word lives in row `addr >> m`, at bits `[s*W +: W]`, where s is the low m address bits. A write changes only those W bits of the row. Bits of `wdata_i` above W are ignored.
- R4: `rdata_o` and `coll_o` change only on the clock edge that samples `re_i` high, and then show that read's result.
- R5: While `re_i` is low, `rdata_o` holds its last value and `coll_o` is 0.
- R6: If both ports are enabled for the same word in the current organisation, `coll_o` is 1 with that read's data, `rdata_o` gives the word's content before the write, and the write takes effect.
- R7: After reset `rdata_o` is 0 and `coll_o` is 0.
- R8: Address bits at and above position 7+m are ignored, both for storage and for the collision test.
- R9: `org_i` changes only while `we_i` and `re_i` are low. Stored bits are read back under the new mapping after a change.
- R10: A write and a read to different words in the same cycle both take effect with `coll_o` = 0, even when they share a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| org_i | input | 3 | Organisation code (see R2) |
| we_i | input | 1 | Write enable |
| waddr_i | input | 12 | Write word address |
| wdata_i | input | 36 | Write data, low W bits used |
| re_i | input | 1 | Read enable |
| raddr_i | input | 12 | Read word address |
| rdata_o | output | 36 | Read data, zero-extended above W |
| coll_o | output | 1 | Read hit a same-word write in the same cycle |

## Verification
The assertions assume that `org_i` is only changed in a cycle where both enables are low. One property checks exactly this, and the others are written on the premise that the organisation in force at a read is the one sampled with it. The stimulus changes the code only on a falling edge after it has lowered both enables, and keeps them low for the next rising edge. Memory is not reset, so the stimulus clears every row before any read result is compared.

// File: rtl/ar_dpram_pkg.sv
package ar_dpram_pkg;

  typedef enum logic [2:0] {
    ORG_128X36 = 3'd0,
    ORG_256X18 = 3'd1,
    ORG_512X9  = 3'd2,
    ORG_1KX4   = 3'd3,
    ORG_2KX2   = 3'd4,
    ORG_4KX1   = 3'd5
  } org_e;

  // log2 of words per row; reserved codes fall back to full width
  function automatic logic [2:0] org_shift(logic [2:0] code);
    case (code)
      ORG_256X18: return 3'd1;
      ORG_512X9:  return 3'd2;
      ORG_1KX4:   return 3'd3;
      ORG_2KX2:   return 3'd4;
      ORG_4KX1:   return 3'd5;
      default:    return 3'd0;
    endcase
  endfunction

  function automatic int unsigned org_width(logic [2:0] sh, int unsigned row_w);
    if (sh <= 3'd2) return row_w >> sh;
    return 32'd1 << (3'd5 - sh);
  endfunction

endpackage

// File: rtl/ar_dpram_addr_map.sv
module ar_dpram_addr_map
  import ar_dpram_pkg::*;
#(
  parameter int unsigned ROWS  = 128,
  parameter int unsigned ROW_W = 36,
  localparam int unsigned ROW_AW = $clog2(ROWS),
  localparam int unsigned ADDR_W = ROW_AW + 5,
  localparam int unsigned OFF_W  = $clog2(ROW_W)
) (
  input  logic [2:0]        org_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ROW_AW-1:0] row_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [OFF_W:0]    wid_o,
  output logic [ROW_W-1:0]  mask_o
);

  logic [2:0]        sh;
  int unsigned       w;
  logic [ADDR_W-1:0] sub;
  logic [63:0]       ones;

  always_comb begin
    sh     = org_shift(org_i);
    w      = org_width(sh, ROW_W);
    row_o  = ROW_AW'(addr_i >> sh);
    sub    = addr_i & ((ADDR_W'(1) << sh) - ADDR_W'(1));
    off_o  = OFF_W'(32'(sub) * w);
    wid_o  = (OFF_W+1)'(w);
    ones   = (64'd1 << w) - 64'd1;
    mask_o = ROW_W'(ones << off_o);
  end

endmodule

// File: rtl/ar_dpram_array.sv
module ar_dpram_array #(
  parameter int unsigned ROWS  = 128,
  parameter int unsigned ROW_W = 36,
  localparam int unsigned ROW_AW = $clog2(ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ROW_AW-1:0] wrow_i,
  input  logic [ROW_W-1:0]  wmask_i,
  input  logic [ROW_W-1:0]  wbits_i,
  input  logic              re_i,
  input  logic [ROW_AW-1:0] rrow_i,
  output logic [ROW_W-1:0]  rrow_o
);

  // one bit column per row bit; mask gates each column's write
  for (genvar c = 0; c < ROW_W; c++) begin : g_col
    logic cell_q [ROWS];
    logic rd_q;

    always_ff @(posedge clk_i) begin
      if (we_i && wmask_i[c]) cell_q[wrow_i] <= wbits_i[c];
    end

    // read-before-write on a shared row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rd_q <= 1'b0;
      else if (re_i) rd_q <= cell_q[rrow_i];
    end

    assign rrow_o[c] = rd_q;
  end

endmodule

// File: rtl/ar_dpram_rd_align.sv
module ar_dpram_rd_align #(
  parameter int unsigned ROW_W = 36,
  localparam int unsigned OFF_W = $clog2(ROW_W)
) (
  input  logic [ROW_W-1:0] row_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [OFF_W:0]   wid_i,
  output logic [ROW_W-1:0] data_o
);

  logic [ROW_W-1:0] shifted;

  assign shifted = row_i >> off_i;

  for (genvar b = 0; b < ROW_W; b++) begin : g_bit
    assign data_o[b] = ((OFF_W+1)'(b) < wid_i) && shifted[b];
  end

endmodule

// File: rtl/ar_dpram.sv
module ar_dpram
  import ar_dpram_pkg::*;
#(
  parameter int unsigned ROWS  = 128,
  parameter int unsigned ROW_W = 36,
  localparam int unsigned ROW_AW = $clog2(ROWS),
  localparam int unsigned ADDR_W = ROW_AW + 5,
  localparam int unsigned OFF_W  = $clog2(ROW_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        org_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [ROW_W-1:0]  wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [ROW_W-1:0]  rdata_o,
  output logic              coll_o
);

  logic [ROW_AW-1:0] wrow, rrow;
  logic [OFF_W-1:0]  woff, roff, roff_q;
  logic [OFF_W:0]    wwid, rwid, rwid_q;
  logic [ROW_W-1:0]  wmask, rmask_unused, wbits, rrow_data;
  logic              hit, coll_q;

  ar_dpram_addr_map #(.ROWS(ROWS), .ROW_W(ROW_W)) u_wmap (
    .org_i (org_i),
    .addr_i(waddr_i),
    .row_o (wrow),
    .off_o (woff),
    .wid_o (wwid),
    .mask_o(wmask)
  );

  ar_dpram_addr_map #(.ROWS(ROWS), .ROW_W(ROW_W)) u_rmap (
    .org_i (org_i),
    .addr_i(raddr_i),
    .row_o (rrow),
    .off_o (roff),
    .wid_o (rwid),
    .mask_o(rmask_unused)
  );

  assign wbits = wdata_i << woff;
  assign hit   = we_i && re_i && (wrow == rrow) && (woff == roff);

  ar_dpram_array #(.ROWS(ROWS), .ROW_W(ROW_W)) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .wrow_i (wrow),
    .wmask_i(wmask),
    .wbits_i(wbits),
    .re_i   (re_i),
    .rrow_i (rrow),
    .rrow_o (rrow_data)
  );

  // slice geometry captured with the read so output is stable while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      roff_q <= '0;
      rwid_q <= '0;
      coll_q <= 1'b0;
    end else begin
      coll_q <= hit;
      if (re_i) begin
        roff_q <= roff;
        rwid_q <= rwid;
      end
    end
  end

  ar_dpram_rd_align #(.ROW_W(ROW_W)) u_align (
    .row_i (rrow_data),
    .off_i (roff_q),
    .wid_i (rwid_q),
    .data_o(rdata_o)
  );

  assign coll_o = coll_q;

  logic unused_ok;
  assign unused_ok = ^{wwid, rmask_unused};

endmodule

// File: rtl/ar_dpram_chk.sv
module ar_dpram_chk #(
  parameter int unsigned ROWS  = 128,
  parameter int unsigned ROW_W = 36,
  localparam int unsigned ADDR_W = $clog2(ROWS) + 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        org_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] waddr_i,
  input logic              re_i,
  input logic [ADDR_W-1:0] raddr_i,
  input logic [ROW_W-1:0]  rdata_o,
  input logic              coll_o
);

  a_r6_same_addr_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && re_i && waddr_i == raddr_i) |=> coll_o);

  a_r10_read_alone_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !we_i) |=> !coll_o);

  a_r5_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> ($stable(rdata_o) && !coll_o));

  a_r2_x1_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && org_i == 3'd5) |=> (rdata_o[ROW_W-1:1] == '0));

  a_r9_org_change_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(org_i) |-> (!we_i && !re_i));

endmodule

bind ar_dpram ar_dpram_chk #(.ROWS(ROWS), .ROW_W(ROW_W)) u_chk (.*);

// File: tb/ar_dpram_tb_top.sv
module ar_dpram_tb_top;

  localparam int AW = 12;
  localparam int DW = 36;
  localparam int NV = 11;
  // {org[2:0], waddr[11:0], wdata[35:0], raddr[11:0], expected[35:0]}
  localparam logic [98:0] VECS [NV] = '{
    {3'd0, 12'd5,     36'h987654321, 12'd5,     36'h987654321},
    {3'd1, 12'd11,    36'h00003ABCD, 12'd11,    36'h00003ABCD},
    {3'd1, 12'd200,   36'h000000000, 12'd10,    36'h000014321},
    {3'd0, 12'd6,     36'h000000000, 12'd5,     36'hEAF354321},
    {3'd2, 12'd27,    36'h0000001A5, 12'd27,    36'h0000001A5},
    {3'd5, 12'd192,   36'h000000001, 12'd219,   36'h000000001},
    {3'd3, 12'd49,    36'hABCDE123F, 12'd48,    36'h000000001},
    {3'd4, 12'd100,   36'h000000002, 12'd98,    36'h000000003},
    {3'd0, 12'd127,   36'hFFFFFFFFF, 12'd6,     36'hD280002F1},
    {3'd0, 12'hF80,   36'h000000001, 12'hF7F,   36'hFFFFFFFFF},
    {3'd0, 12'd300,   36'h000000000, 12'd0,     36'h000000001}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    org_i = '0;
  logic          we_i = 1'b0;
  logic [AW-1:0] waddr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic          re_i = 1'b0;
  logic [AW-1:0] raddr_i = '0;
  logic [DW-1:0] rdata_o;
  logic          coll_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  ar_dpram dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .org_i(org_i),
    .we_i(we_i), .waddr_i(waddr_i), .wdata_i(wdata_i),
    .re_i(re_i), .raddr_i(raddr_i), .rdata_o(rdata_o), .coll_o(coll_o)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_org(logic [2:0] o);
    @(negedge clk_i);
    we_i = 1'b0; re_i = 1'b0; org_i = o;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk_i);
    we_i = 1'b1; waddr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d, output logic c);
    @(negedge clk_i);
    re_i = 1'b1; raddr_i = a;
    @(negedge clk_i);
    re_i = 1'b0;
    d = rdata_o; c = coll_o;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic          c;
    logic [98:0]   v;

    repeat (3) @(negedge clk_i);
    check("R7 reset rdata", rdata_o, '0);
    check("R7 reset coll", {35'd0, coll_o}, '0);
    rst_ni = 1'b1;

    // clear storage in full-width organisation
    set_org(3'd0);
    for (int r = 0; r < 128; r++) begin
      @(negedge clk_i);
      we_i = 1'b1; waddr_i = AW'(r); wdata_i = '0;
    end
    @(negedge clk_i);
    we_i = 1'b0;

    // R1 R2 R3 R8 R9: table walk across organisations
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      set_org(v[98:96]);
      wr(v[95:84], v[83:48]);
      rd(v[47:36], d, c);
      check($sformatf("R1 R2 R3 R8 R9 vector %0d", i), d, v[35:0]);
    end

    // R6: same-word collision returns old data, write lands
    set_org(3'd0);
    @(negedge clk_i);
    we_i = 1'b1; waddr_i = 12'd3; wdata_i = 36'h00000A5A5;
    re_i = 1'b1; raddr_i = 12'd3;
    @(negedge clk_i);
    we_i = 1'b0; re_i = 1'b0;
    check("R6 coll flag", {35'd0, coll_o}, 36'd1);
    check("R6 old data", rdata_o, 36'd0);
    rd(12'd3, d, c);
    check("R6 write landed", d, 36'h00000A5A5);
    check("R6 flag clears", {35'd0, c}, 36'd0);

    // R8: aliased upper bits still collide
    @(negedge clk_i);
    we_i = 1'b1; waddr_i = 12'h083; wdata_i = 36'h5;
    re_i = 1'b1; raddr_i = 12'h003;
    @(negedge clk_i);
    we_i = 1'b0; re_i = 1'b0;
    check("R8 alias coll", {35'd0, coll_o}, 36'd1);
    check("R8 alias old data", rdata_o, 36'h00000A5A5);
    rd(12'd3, d, c);
    check("R8 alias write", d, 36'h5);

    // R10: same row, different sub-word
    set_org(3'd1);
    @(negedge clk_i);
    we_i = 1'b1; waddr_i = 12'd8; wdata_i = 36'h22222;
    re_i = 1'b1; raddr_i = 12'd9;
    @(negedge clk_i);
    we_i = 1'b0; re_i = 1'b0;
    check("R10 no coll", {35'd0, coll_o}, 36'd0);
    check("R10 read data", rdata_o, 36'd0);
    rd(12'd8, d, c);
    check("R10 write landed", d, 36'h22222);

    // R5: idle read port holds output while writes continue
    @(negedge clk_i);
    raddr_i = 12'd9; we_i = 1'b1; waddr_i = 12'd9; wdata_i = 36'h1;
    @(negedge clk_i);
    we_i = 1'b0;
    check("R5 hold data", rdata_o, 36'h22222);
    check("R5 hold coll", {35'd0, coll_o}, 36'd0);
    @(negedge clk_i);
    check("R5 hold data later", rdata_o, 36'h22222);

    // R4: output moves only at the sampling edge
    @(negedge clk_i);
    re_i = 1'b1; raddr_i = 12'd9;
    #1;
    check("R4 before edge", rdata_o, 36'h22222);
    @(negedge clk_i);
    re_i = 1'b0;
    check("R4 after edge", rdata_o, 36'h1);

    // R2: reserved code acts as full width
    set_org(3'd6);
    rd(12'd5, d, c);
    check("R2 reserved code", d, 36'hEAF354321);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule